// File: doc/BRIEF.md
# Shared Time Base and Watchdog Timer

This block is a small timer unit with one binary divider that serves two users: a periodic interrupt source and a watchdog. A tick-enable input advances the divider, either directly or through a divide-by-8 prescaler when the enable runs eight times too fast. A 3-bit select picks which divider stage acts as the tap. The watchdog counts tap events in a short counter. When that counter wraps, a sticky timeout flag is set.

A host drives the unit through single-cycle one-hot command pulses. These turn the whole unit on or off, start or stop the shared divider, and choose whether the interrupt pin carries the watchdog timeout or the periodic tick. Other pulses clear the counters and enable or release the pin. The interrupt output is active low and has a separate output-enable, so a pad can place it in high impedance.

Top module: `tmr_wdog`

## Requirements
- R1: After reset the unit is disabled, the divider is stopped, nothing is routed to the interrupt, `irqOe` is 0, `irqN` is 1, `wdtFlag` is 0 and the latched tap select is 0.
- R2: `cmd` bits: 0 unit on, 1 unit off, 2 watchdog start, 3 divider stop, 4 timer start, 5 clear watchdog, 6 clear divider, 7 interrupt enable, 8 interrupt release. A command sampled at a rising edge is visible on the outputs after that edge.
- R3: While the unit is on, every `tickIn` is a base tick when `fastSrc` is 0. When `fastSrc` is 1, every eighth `tickIn` is a base tick.
- R4: While the divider runs, tap select n yields one tap event every 2^n base ticks, counted from the last divider clear.
- R5: The fourth tap event after a watchdog clear sets `wdtFlag` at that edge. The flag stays set until a watchdog clear or reset, and the watchdog counter wraps and keeps counting.
- R6: Bit 2 and bit 4 both start the divider. Bit 2 routes the watchdog and bit 4 routes the timer, and bit 4 wins when both arrive together. Bit 3 stops the divider, so neither tap events nor timeouts occur, and it wins over a start in the same cycle.
- R7: When the watchdog is routed, `irqN` goes low after each timeout edge. It stays low until a watchdog clear or an interrupt release.
- R8: When the timer is routed, `irqN` goes low after each tap event. It returns high after the next base tick that is not itself a tap event.
- R9: Clear watchdog zeroes the divider, the watchdog counter and `wdtFlag`. Clear divider zeroes only the divider. A clear overrides a count or tap event in the same cycle.
- R10: Bit 7 sets `irqOe` and bit 8 clears it, with bit 8 winning. `irqN` keeps showing the routed level either way.
- R11: While the unit is off, the prescaler, divider and watchdog hold and `wdtFlag` cannot rise. Commands are still accepted.
- R12: `freqSel` is taken only in a cycle that carries clear watchdog or clear divider. At other times it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickIn | input | 1 | Source tick enable |
| fastSrc | input | 1 | 1 selects the divide-by-8 prescaler |
| freqSel | input | 3 | Divider tap select n |
| cmd | input | 9 | One-hot command pulses |
| irqN | output | 1 | Active-low interrupt level |
| irqOe | output | 1 | Interrupt output enable |
| wdtFlag | output | 1 | Sticky watchdog timeout flag |

## Verification
The bench uses the default parameters: an 8-stage divider, a 2-stage watchdog and a 3-stage prescaler. With `tickIn` held high, even the slowest tap combined with the prescaler reaches a timeout in about 4100 cycles. This brings the largest divider stage, the prescaler wrap and the watchdog wrap within a short run. Randomized tick gaps and command pulses exercise coincident clears, counts and route changes against the behavioural model.

// File: rtl/tmr_wdog_pkg.sv
package tmr_wdog_pkg;
  localparam int CMD_W       = 9;
  localparam int CMD_SYS_ON  = 0;
  localparam int CMD_SYS_OFF = 1;
  localparam int CMD_WDT_ON  = 2;
  localparam int CMD_RUN_OFF = 3;
  localparam int CMD_TMR_ON  = 4;
  localparam int CMD_CLR_WDT = 5;
  localparam int CMD_CLR_DIV = 6;
  localparam int CMD_IRQ_ON  = 7;
  localparam int CMD_IRQ_OFF = 8;

  typedef enum logic [1:0] {SRC_NONE = 2'd0, SRC_WDT = 2'd1, SRC_TMR = 2'd2} irqSrc_t;

  typedef struct packed {
    logic sysEn;
    logic run;
    logic divClr;
    logic wdClr;
  } dpCtl_t;
endpackage

// File: rtl/tmr_wdog_dp.sv
module tmr_wdog_dp
  import tmr_wdog_pkg::*;
#(
  parameter int DIV_STAGES  = 8,
  parameter int WDOG_STAGES = 2,
  parameter int PRE_STAGES  = 3,
  parameter int SEL_W       = $clog2(DIV_STAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tickIn,
  input  logic             fastSrc,
  input  logic [SEL_W-1:0] freqSel,
  input  dpCtl_t           ctl,
  output logic             baseTick,
  output logic             tapEvt,
  output logic             wdOvf,
  output logic             wdtFlag
);
  localparam logic [DIV_STAGES-1:0] DIV_ONE = DIV_STAGES'(1);

  logic                   preWrap;
  logic [DIV_STAGES-1:0]  divQ;
  logic [DIV_STAGES-1:0]  tapMask;
  logic [SEL_W-1:0]       selQ;
  logic [WDOG_STAGES-1:0] wdQ;
  logic                   flagQ;

  generate
    if (PRE_STAGES > 0) begin : g_pre
      logic [PRE_STAGES-1:0] preQ;
      always_ff @(posedge clk) begin
        if (rst) preQ <= '0;
        else if (ctl.sysEn && tickIn && fastSrc) preQ <= preQ + 1'b1;
      end
      assign preWrap = &preQ;
    end else begin : g_nopre
      assign preWrap = 1'b1;
    end
  endgenerate

  assign baseTick = ctl.sysEn & tickIn & (~fastSrc | preWrap);
  assign tapMask  = (DIV_ONE << selQ) - DIV_ONE;
  assign tapEvt   = baseTick & ctl.run & ~ctl.divClr & (&(divQ | ~tapMask));
  assign wdOvf    = tapEvt & (&wdQ);
  assign wdtFlag  = flagQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      divQ <= '0;
      selQ <= '0;
    end else if (ctl.divClr) begin
      divQ <= '0;
      selQ <= freqSel;
    end else if (baseTick && ctl.run) begin
      divQ <= divQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.wdClr) begin
      wdQ   <= '0;
      flagQ <= 1'b0;
    end else if (tapEvt) begin
      wdQ <= wdQ + 1'b1;
      if (&wdQ) flagQ <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_wdog_ctrl.sv
module tmr_wdog_ctrl
  import tmr_wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd,
  input  logic             baseTick,
  input  logic             tapEvt,
  input  logic             wdOvf,
  output dpCtl_t           ctl,
  output logic             irqN,
  output logic             irqOe
);
  logic    sysEnQ;
  logic    runQ;
  irqSrc_t srcQ;
  logic    oeQ;
  logic    wdLowQ;
  logic    pulseQ;

  assign ctl.sysEn  = sysEnQ;
  assign ctl.run    = runQ;
  assign ctl.divClr = cmd[CMD_CLR_WDT] | cmd[CMD_CLR_DIV];
  assign ctl.wdClr  = cmd[CMD_CLR_WDT];

  always_ff @(posedge clk) begin
    if (rst) begin
      sysEnQ <= 1'b0;
      runQ   <= 1'b0;
      srcQ   <= SRC_NONE;
      oeQ    <= 1'b0;
    end else begin
      if (cmd[CMD_SYS_OFF])      sysEnQ <= 1'b0;
      else if (cmd[CMD_SYS_ON])  sysEnQ <= 1'b1;
      if (cmd[CMD_RUN_OFF])      runQ <= 1'b0;
      else if (cmd[CMD_WDT_ON] || cmd[CMD_TMR_ON]) runQ <= 1'b1;
      if (cmd[CMD_TMR_ON])       srcQ <= SRC_TMR;
      else if (cmd[CMD_WDT_ON])  srcQ <= SRC_WDT;
      if (cmd[CMD_IRQ_OFF])      oeQ <= 1'b0;
      else if (cmd[CMD_IRQ_ON])  oeQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wdLowQ <= 1'b0;
      pulseQ <= 1'b0;
    end else begin
      if (cmd[CMD_CLR_WDT] || cmd[CMD_IRQ_OFF]) wdLowQ <= 1'b0;
      else if (wdOvf)                           wdLowQ <= 1'b1;
      if (tapEvt)        pulseQ <= 1'b1;
      else if (baseTick) pulseQ <= 1'b0;
    end
  end

  always_comb begin
    unique case (srcQ)
      SRC_WDT: irqN = ~wdLowQ;
      SRC_TMR: irqN = ~pulseQ;
      default: irqN = 1'b1;
    endcase
  end

  assign irqOe = oeQ;
endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog
  import tmr_wdog_pkg::*;
#(
  parameter int DIV_STAGES  = 8,
  parameter int WDOG_STAGES = 2,
  parameter int PRE_STAGES  = 3,
  parameter int SEL_W       = $clog2(DIV_STAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tickIn,
  input  logic             fastSrc,
  input  logic [SEL_W-1:0] freqSel,
  input  logic [CMD_W-1:0] cmd,
  output logic             irqN,
  output logic             irqOe,
  output logic             wdtFlag
);
  dpCtl_t ctl;
  logic   baseTick;
  logic   tapEvt;
  logic   wdOvf;

  tmr_wdog_ctrl uCtrl (
    .clk(clk), .rst(rst), .cmd(cmd),
    .baseTick(baseTick), .tapEvt(tapEvt), .wdOvf(wdOvf),
    .ctl(ctl), .irqN(irqN), .irqOe(irqOe)
  );

  tmr_wdog_dp #(
    .DIV_STAGES(DIV_STAGES), .WDOG_STAGES(WDOG_STAGES),
    .PRE_STAGES(PRE_STAGES), .SEL_W(SEL_W)
  ) uDp (
    .clk(clk), .rst(rst), .tickIn(tickIn), .fastSrc(fastSrc),
    .freqSel(freqSel), .ctl(ctl),
    .baseTick(baseTick), .tapEvt(tapEvt), .wdOvf(wdOvf), .wdtFlag(wdtFlag)
  );
endmodule

// File: rtl/tmr_wdog_chk.sv
module tmr_wdog_chk
  import tmr_wdog_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [CMD_W-1:0] cmd,
  input logic             irqN,
  input logic             irqOe,
  input logic             wdtFlag,
  input logic             sysEnQ
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irqOe && irqN && !wdtFlag)); // R1
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wdtFlag && !cmd[CMD_CLR_WDT]) |=> wdtFlag); // R5
  AST_CLR_WDT: assert property (@(posedge clk) disable iff (rst)
    cmd[CMD_CLR_WDT] |=> !wdtFlag); // R9
  AST_OE_SET: assert property (@(posedge clk) disable iff (rst)
    (cmd[CMD_IRQ_ON] && !cmd[CMD_IRQ_OFF]) |=> irqOe); // R10
  AST_OE_CLR: assert property (@(posedge clk) disable iff (rst)
    cmd[CMD_IRQ_OFF] |=> !irqOe); // R10
  AST_FLAG_NEEDS_SYS: assert property (@(posedge clk) disable iff (rst)
    $rose(wdtFlag) |-> $past(sysEnQ)); // R11
endmodule

bind tmr_wdog tmr_wdog_chk uChk (
  .clk(clk), .rst(rst), .cmd(cmd), .irqN(irqN), .irqOe(irqOe),
  .wdtFlag(wdtFlag), .sysEnQ(uCtrl.sysEnQ)
);

// File: tb/tb_tmr_wdog.sv
`timescale 1ns/1ps
module tb_tmr_wdog;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickIn = 1'b0;
  logic       fastSrc = 1'b0;
  logic [2:0] freqSel = 3'd0;
  logic [8:0] cmd = 9'd0;
  logic       irqN, irqOe, wdtFlag;

  tmr_wdog dut (.clk(clk), .rst(rst), .tickIn(tickIn), .fastSrc(fastSrc),
                .freqSel(freqSel), .cmd(cmd), .irqN(irqN), .irqOe(irqOe),
                .wdtFlag(wdtFlag));

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0, tickRand = 0, tickOn = 0;
  string phase = "R1";
  logic [31:0] lfsr = 32'h1234_5678;

  // behavioural reference state
  int mPre, mDiv, mWd, mSel, mSrc;
  bit mFlag, mSys, mRun, mOe, mLatch, mPulse;

  task automatic check(string req, logic act, logic exp, string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit expIrqN();
    if (mSrc == 1) return !mLatch;
    if (mSrc == 2) return !mPulse;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mPre = 0; mDiv = 0; mWd = 0; mSel = 0; mSrc = 0;
      mFlag = 0; mSys = 0; mRun = 0; mOe = 0; mLatch = 0; mPulse = 0;
    end else begin
      bit bt, clrD, tap, ovf;
      int span;
      span = 1 << mSel;
      bt   = mSys && tickIn && (!fastSrc || mPre == 7);
      clrD = cmd[5] || cmd[6];
      tap  = bt && mRun && !clrD && ((mDiv % span) == span - 1);
      ovf  = tap && mWd == 3;
      if (mSys && tickIn && fastSrc) mPre = (mPre + 1) % 8;
      if (clrD) begin mDiv = 0; mSel = freqSel; end
      else if (bt && mRun) mDiv = (mDiv + 1) % 256;
      if (cmd[5]) begin mWd = 0; mFlag = 0; end
      else if (tap) begin mWd = (mWd + 1) % 4; if (ovf) mFlag = 1; end
      if (cmd[1]) mSys = 0; else if (cmd[0]) mSys = 1;
      if (cmd[3]) mRun = 0; else if (cmd[2] || cmd[4]) mRun = 1;
      if (cmd[4]) mSrc = 2; else if (cmd[2]) mSrc = 1;
      if (cmd[8]) mOe = 0; else if (cmd[7]) mOe = 1;
      if (cmd[5] || cmd[8]) mLatch = 0; else if (ovf) mLatch = 1;
      if (tap) mPulse = 1; else if (bt) mPulse = 0;
    end
    if (cycles == 150000 && !done) begin
      mismatched++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst && cycles > 0) begin
      check(phase, irqN, expIrqN(), "irqN");
      check(phase, irqOe, mOe, "irqOe");
      check(phase, wdtFlag, mFlag, "wdtFlag");
    end
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    tickIn = tickRand ? lfsr[3] : tickOn;
  end

  task automatic send(input logic [8:0] c);
    cmd = c;
    @(negedge clk);
    cmd = 9'd0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    check("R1", irqOe, 1'b0, "reset irqOe");
    check("R1", irqN, 1'b1, "reset irqN");
    check("R1", wdtFlag, 1'b0, "reset wdtFlag");

    phase = "R11"; tickOn = 1;
    send(9'h004); send(9'h080);
    idle(60);
    check("R11", wdtFlag, 1'b0, "no timeout while off");

    phase = "R2"; freqSel = 3'd0;
    send(9'h001); send(9'h020);
    idle(8);
    phase = "R7";
    check("R7", wdtFlag, 1'b1, "timeout at tap 0");
    check("R7", irqN, 1'b0, "irq held low");
    send(9'h100);
    check("R10", irqOe, 1'b0, "released");
    check("R10", irqN, 1'b1, "latch cleared by release");
    send(9'h080);
    phase = "R9";
    send(9'h020);
    check("R9", wdtFlag, 1'b0, "flag cleared");
    idle(20);

    phase = "R12"; freqSel = 3'd3;
    idle(40);
    send(9'h040);
    freqSel = 3'd1;
    idle(60);

    phase = "R8"; tickRand = 1; freqSel = 3'd2;
    send(9'h050);
    idle(300);
    phase = "R4"; freqSel = 3'd5;
    send(9'h040);
    idle(500);

    phase = "R3"; tickRand = 0; fastSrc = 1; freqSel = 3'd7;
    send(9'h024);
    idle(4300);
    check("R3", wdtFlag, 1'b1, "slowest tap with prescaler");

    phase = "R6";
    send(9'h028);
    send(9'h020);
    idle(300);
    check("R6", wdtFlag, 1'b0, "stopped divider never times out");
    send(9'h014);
    fastSrc = 0; freqSel = 3'd1;
    send(9'h040);
    idle(100);

    phase = "R11";
    send(9'h002);
    idle(50);
    send(9'h024);
    idle(20);
    send(9'h001);
    idle(60);

    phase = "R5"; tickRand = 1; freqSel = 3'd0;
    send(9'h024);
    for (int i = 0; i < 3000; i++) begin
      if (lfsr[9:5] == 5'd3) send(9'(1) << (lfsr[15:12] % 9));
      else if (lfsr[9:5] == 5'd7) send(9'(lfsr[20:12]) | 9'h001);
      else begin
        freqSel = lfsr[26:24];
        @(negedge clk);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule